// File: doc/BRIEF.md
# Hot-Swap Two-Segment Bus Link Controller

This block is the control core of a buffer that sits between a plug-in card's two-wire serial bus (data and clock) and the matching bus on a live backplane. While the card's supplies are not yet good it keeps the two segments apart and asks an analog stage to bias the pins toward a mid-level, so that the moment of insertion disturbs the backplane as little as possible.

Once the supplies are good, the block assumes the backplane is in the middle of a transfer. It waits until that transfer has plainly ended, either through a STOP condition or through a long stretch of idle-high lines. It then waits until the card's own lines are both high, and only then joins the segments. When joined, each line behaves as one wired-AND net spanning both sides, so clock stretching, arbitration and acknowledge keep working. Line levels are modelled digitally: every open-drain device on a side is summarised by one pulldown-request input, and the block reports the level each pin resolves to.

Top module: `hsb_link_top`

## Requirements
- R1: While `sup_a_ok` is low, `precharge_en` is 1 and `linked` is 0, whatever the pulldown inputs do.
- R2: With `CHECK_SUP_B`=1 (the default), `sup_b_ok` low also holds the block in lockout: `precharge_en` stays 1 and `linked` stays 0 even with all lines high for longer than the idle window.
- R3: Once every checked supply flag is high, `precharge_en` drops to 0 within two clock cycles.
- R4: After lockout, `linked` stays 0 until a STOP (backplane SDA going from low to high over two consecutive synchronized samples in which backplane SCL is high) or a bus-idle event is seen.
- R5: Bus idle is `IDLE_CYCLES` (1023 by default) consecutive synchronized samples with both backplane lines high; a low on either line restarts the count.
- R6: After a STOP or idle event, `linked` rises only once the card SDA and SCL are both high (synchronized); it rises within six cycles of both going high.
- R7: While linked, a pulldown request on the data line from either side makes `card_sda` and `bp_sda` both 0.
- R8: While linked, a pulldown request on the clock line from either side makes `card_scl` and `bp_scl` both 0; each line reads 1 on both sides only when no request on either side pulls it.
- R9: While not linked, each side's output levels are the inverse of that side's own pulldown requests only (1 = request to pull low, 0 = released).
- R10: A drop of any checked supply flag makes `linked` 0 and `precharge_en` 1 in the same cycle, isolating the segments at once, and the whole start-up sequence must then be repeated.
- R11: Levels are resolved from the pulldown inputs alone: after all requests are released, a linked line returns high on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_a_ok | input | 1 | Primary supply-good flag |
| sup_b_ok | input | 1 | Secondary supply-good flag (used when `CHECK_SUP_B`=1) |
| card_sda_pull | input | 1 | Card-side data line pulldown request (1 = pull low) |
| card_scl_pull | input | 1 | Card-side clock line pulldown request (1 = pull low) |
| bp_sda_pull | input | 1 | Backplane data line pulldown request (1 = pull low) |
| bp_scl_pull | input | 1 | Backplane clock line pulldown request (1 = pull low) |
| card_sda | output | 1 | Resolved card-side data level |
| card_scl | output | 1 | Resolved card-side clock level |
| bp_sda | output | 1 | Resolved backplane data level |
| bp_scl | output | 1 | Resolved backplane clock level |
| precharge_en | output | 1 | Mid-level bias enable, high during lockout |
| linked | output | 1 | Segments joined |

## Verification
The two events that can land on the same cycle are a supply drop and the moment the controller would otherwise join the segments or keep them joined; the supply drop must win at once. The bench drops the primary flag while the segments are linked and checks, one time step later, that `linked` is already 0, precharge is back on and a card-side pulldown no longer reaches the backplane. It also lets a backplane clock glitch fall in the middle of an idle count so that a restart is distinguishable from an idle link that would otherwise have happened hundreds of cycles earlier.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [1:0] {
    ST_LOCK      = 2'd0,
    ST_WAIT_END  = 2'd1,
    ST_WAIT_CARD = 2'd2,
    ST_LINK      = 2'd3
  } hsb_state_e;
endpackage

// File: rtl/hsb_sync2.sv
module hsb_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/hsb_end_det.sv
module hsb_end_det #(
  parameter int IDLE_CYCLES = 1023
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sda_s,
  input  logic scl_s,
  output logic stop_o,
  output logic idle_o
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(IDLE_CYCLES);

  logic          prev_sda_q, prev_scl_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr || !(sda_s && scl_s)) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != CMAX) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      prev_sda_q <= 1'b1;
      prev_scl_q <= 1'b1;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      prev_sda_q <= sda_s;
      prev_scl_q <= scl_s;
    end
  end

  assign stop_o = sda_s && !prev_sda_q && scl_s && prev_scl_q;
  assign idle_o = (cnt_q == CMAX);

  // R5
  idle_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> $past(sda_s && scl_s));
endmodule

// File: rtl/hsb_seq_fsm.sv
module hsb_seq_fsm
  import hsb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_ok,
  input  logic       end_stop,
  input  logic       end_idle,
  input  logic       card_hi,
  output hsb_state_e st_o
);
  hsb_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!sup_ok) begin
      st_d = ST_LOCK;
    end else begin
      unique case (st_q)
        ST_LOCK:      st_d = ST_WAIT_END;
        ST_WAIT_END:  if (end_stop || end_idle) st_d = ST_WAIT_CARD;
        ST_WAIT_CARD: if (card_hi) st_d = ST_LINK;
        ST_LINK:      st_d = ST_LINK;
        default:      st_d = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_LOCK;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

  // R1
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |=> (st_q == ST_LOCK));
  // R4
  end_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT_CARD && $past(st_q) == ST_WAIT_END) |-> $past(end_stop || end_idle));
  // R6
  card_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_LINK) |-> $past(card_hi));
endmodule

// File: rtl/hsb_link_top.sv
module hsb_link_top
  import hsb_pkg::*;
#(
  parameter int IDLE_CYCLES = 1023,
  parameter bit CHECK_SUP_B = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_a_ok,
  input  logic sup_b_ok,
  input  logic card_sda_pull,
  input  logic card_scl_pull,
  input  logic bp_sda_pull,
  input  logic bp_scl_pull,
  output logic card_sda,
  output logic card_scl,
  output logic bp_sda,
  output logic bp_scl,
  output logic precharge_en,
  output logic linked
);
  logic       rst_s1_q, rst_s2_q;
  logic       sup_ok;
  logic [3:0] lvl_s;
  logic       stop_ev, idle_ev;
  hsb_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  generate
    if (CHECK_SUP_B) begin : g_dual_sup
      assign sup_ok = sup_a_ok && sup_b_ok;
    end else begin : g_single_sup
      logic unused_sup_b;
      assign unused_sup_b = sup_b_ok;
      assign sup_ok = sup_a_ok;
    end
  endgenerate

  hsb_sync2 #(.W(4)) u_sync (
    .clk   (clk),
    .rst_n (rst_s2_q),
    .d     ({~bp_sda_pull, ~bp_scl_pull, ~card_sda_pull, ~card_scl_pull}),
    .q     (lvl_s)
  );

  hsb_end_det #(.IDLE_CYCLES(IDLE_CYCLES)) u_end (
    .clk    (clk),
    .rst_n  (rst_s2_q),
    .clr    (st == ST_LOCK),
    .sda_s  (lvl_s[3]),
    .scl_s  (lvl_s[2]),
    .stop_o (stop_ev),
    .idle_o (idle_ev)
  );

  hsb_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .sup_ok   (sup_ok),
    .end_stop (stop_ev),
    .end_idle (idle_ev),
    .card_hi  (lvl_s[1] && lvl_s[0]),
    .st_o     (st)
  );

  assign linked       = (st == ST_LINK) && sup_ok;
  assign precharge_en = (st == ST_LOCK) || !sup_ok;

  assign card_sda = !card_sda_pull && !(linked && bp_sda_pull);
  assign bp_sda   = !bp_sda_pull   && !(linked && card_sda_pull);
  assign card_scl = !card_scl_pull && !(linked && bp_scl_pull);
  assign bp_scl   = !bp_scl_pull   && !(linked && card_scl_pull);

  // R7
  sda_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    linked |-> (card_sda == bp_sda));
  // R8
  scl_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    linked |-> (card_scl == bp_scl));
  // R1
  lock_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_a_ok |-> (precharge_en && !linked));
endmodule

// File: tb/sim_hsb_link_top.sv
module sim_hsb_link_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_a_ok = 1'b0, sup_b_ok = 1'b0;
  logic card_sda_pull = 1'b0, card_scl_pull = 1'b0;
  logic bp_sda_pull = 1'b0, bp_scl_pull = 1'b0;
  logic card_sda, card_scl, bp_sda, bp_scl, precharge_en, linked;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  hsb_link_top u0 (
    .clk(clk), .rst_n(rst_n), .sup_a_ok(sup_a_ok), .sup_b_ok(sup_b_ok),
    .card_sda_pull(card_sda_pull), .card_scl_pull(card_scl_pull),
    .bp_sda_pull(bp_sda_pull), .bp_scl_pull(bp_scl_pull),
    .card_sda(card_sda), .card_scl(card_scl), .bp_sda(bp_sda), .bp_scl(bp_scl),
    .precharge_en(precharge_en), .linked(linked)
  );

  // pulls {card_sda, card_scl, bp_sda, bp_scl}, expected {card_sda, card_scl, bp_sda, bp_scl}
  localparam logic [7:0] VEC [9] = '{
    8'b0000_1111, 8'b1000_0101, 8'b0010_0101, 8'b0100_1010, 8'b0001_1010,
    8'b1001_0000, 8'b1010_0101, 8'b1111_0000, 8'b0000_1111
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pulls(input logic [3:0] p);
    {card_sda_pull, card_scl_pull, bp_sda_pull, bp_scl_pull} = p;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(5);
    // R1 reset state and lockout
    chk("R1 precharge", precharge_en, 1);
    chk("R1 linked", linked, 0);
    for (int i = 0; i < 6; i++) begin
      bp_sda_pull = ~bp_sda_pull;
      step(2);
    end
    bp_sda_pull = 1'b0;
    card_sda_pull = 1'b1;
    #1;
    // R9 isolation during lockout
    chk("R9 card_sda", card_sda, 0);
    chk("R9 bp_sda", bp_sda, 1);
    card_sda_pull = 1'b0;
    chk("R1 linked after activity", linked, 0);

    // R2 secondary flag still low
    sup_a_ok = 1'b1;
    step(1100);
    chk("R2 precharge", precharge_en, 1);
    chk("R2 linked", linked, 0);

    // mid-transaction start: backplane SDA low, card SDA low
    bp_sda_pull = 1'b1;
    card_sda_pull = 1'b1;
    sup_b_ok = 1'b1;
    step(2);
    chk("R3 precharge off", precharge_en, 0);
    step(50);
    chk("R4 no end yet", linked, 0);
    bp_sda_pull = 1'b0;   // STOP: SDA rises while SCL high
    step(10);
    chk("R6 card low blocks", linked, 0);
    #1;
    chk("R9 card_sda", card_sda, 0);
    chk("R9 bp_sda", bp_sda, 1);
    card_sda_pull = 1'b0;
    step(6);
    chk("R4 R6 linked after stop", linked, 1);

    // R7 R8 R11 wired-AND table
    for (int i = 0; i < 9; i++) begin
      set_pulls(VEC[i][7:4]);
      #1;
      chk($sformatf("R7 R8 R11 vec%0d", i), {card_sda, card_scl, bp_sda, bp_scl}, VEC[i][3:0]);
      step(1);
    end

    // R10 supply drop isolates at once
    sup_a_ok = 1'b0;
    #1;
    chk("R10 linked", linked, 0);
    chk("R10 precharge", precharge_en, 1);
    card_sda_pull = 1'b1;
    #1;
    chk("R10 isolation", bp_sda, 1);
    card_sda_pull = 1'b0;
    step(5);

    // R5 idle count with restart
    sup_a_ok = 1'b1;
    step(500);
    bp_scl_pull = 1'b1;
    step(1);
    bp_scl_pull = 1'b0;
    step(800);
    chk("R5 restart", linked, 0);
    step(300);
    chk("R5 idle link", linked, 1);
    chk("R3 precharge", precharge_en, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule